// File: doc/BRIEF.md
# Reversible Shift-Add Multiply-Accumulate Unit

This block multiplies two unsigned operands and folds the product into an accumulator register. It never overwrites that register with the product. When `start` is accepted, the block takes a copy of both operands and loads the accumulator from `acc_in`. It then walks the multiplier bits from position 0 up to position WIDTH-1, one bit per clock. For every set bit it adds the multiplicand, shifted left by that position, into the accumulator. All arithmetic wraps modulo 2^WIDTH, so bits shifted beyond the top are lost.

When `reverse` is high at the accepted start, every selected partial product is subtracted instead of added. A forward run followed by a reverse run with the same operands therefore returns the accumulator to the value it held before the forward run, which makes the unit usable as an undo step in a reversible datapath.

The controller has three states. IDLE waits for `start`; the transition IDLE to RUN (accept) loads the accumulator and captures the operands. RUN processes one bit position per cycle; RUN to RUN (step) moves to the next position, and RUN to FIN (last step) follows the top bit. FIN raises `done` for one cycle, and FIN to IDLE (release) returns control. `busy` is high in RUN and FIN.

Top module: `rev_mac`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `acc_out` is 0.
- R2: A `start` seen in IDLE loads `acc_out` from `acc_in` and captures `op_a`, `op_b` and `reverse`; `busy` is 1 in the cycle after that edge.
- R3: With `reverse`=0, the final `acc_out` equals (acc_in + op_a*op_b) mod 2^WIDTH.
- R4: With `reverse`=1, the final `acc_out` equals (acc_in - op_a*op_b) mod 2^WIDTH.
- R5: `done` is 1 for exactly one cycle, starting WIDTH clock edges after the edge that accepts `start`; `busy` stays 1 from the accept edge through the `done` cycle and is 0 afterwards.
- R6: A `start` while `busy` is 1 is ignored, and input changes while `busy` is 1 do not affect the result.
- R7: A forward run followed by a reverse run with the same operands, where the reverse run's `acc_in` is the forward result, ends with the original `acc_in`.
- R8: While idle and without an accepted `start`, `acc_out` holds its value whatever `acc_in` does.
- R9: In a step whose multiplier bit is 0, the accumulator is unchanged; it only moves by a shifted copy of the multiplicand.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a run; accepted only in IDLE |
| reverse | input | 1 | 0 adds partial products, 1 subtracts them |
| op_a | input | WIDTH | Multiplier, scanned bit by bit |
| op_b | input | WIDTH | Multiplicand, shifted per position |
| acc_in | input | WIDTH | Accumulator value loaded at accept |
| acc_out | output | WIDTH | Accumulator register |
| busy | output | 1 | High in RUN and FIN |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the unit with WIDTH=4. At that width every pair of 4-bit operands can be run in both directions with a varying start accumulator, so the modular wrap of both sum and difference, and the dropping of shifted-out bits, are covered for every input pair. The same small width keeps the latency short enough to check the `done` and `busy` timing cycle by cycle on every run, and to disturb a run in progress with a second `start` and new inputs.

// File: rtl/rev_mac_pkg.sv
package rev_mac_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } mac_state_t;

endpackage

// File: rtl/rev_mac_ctrl.sv
module rev_mac_ctrl
    import rev_mac_pkg::*;
#(
    parameter int WIDTH = 32,
    localparam int POS_W = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             load,
    output logic             step_en,
    output logic [POS_W-1:0] pos,
    output logic             busy,
    output logic             done
);

    localparam logic [POS_W-1:0] LAST_POS = POS_W'(WIDTH - 1);

    mac_state_t state_q, state_d;
    logic [POS_W-1:0] pos_q;

    // state register and bit-position counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pos_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE)
                pos_q <= '0;
            else if (state_q == ST_RUN)
                pos_q <= pos_q + 1'b1;
        end
    end

    // transitions: accept, step, last step, release
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_RUN;
            ST_RUN:  if (pos_q == LAST_POS) state_d = ST_FIN;
            ST_FIN:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs decoded from the current state
    always_comb begin
        load    = 1'b0;
        step_en = 1'b0;
        busy    = 1'b0;
        done    = 1'b0;
        unique case (state_q)
            ST_IDLE: load = start;
            ST_RUN: begin
                step_en = 1'b1;
                busy    = 1'b1;
            end
            ST_FIN: begin
                busy = 1'b1;
                done = 1'b1;
            end
            default: ;
        endcase
    end

    assign pos = pos_q;

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5
    run_to_fin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && pos_q == LAST_POS) |=> done);

endmodule

// File: rtl/rev_mac_datapath.sv
module rev_mac_datapath #(
    parameter int WIDTH = 32,
    localparam int POS_W = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step_en,
    input  logic [POS_W-1:0] pos,
    input  logic             reverse,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic [WIDTH-1:0] acc_in,
    output logic [WIDTH-1:0] acc_out
);

    logic [WIDTH-1:0] a_q, b_q, acc_q, partial;
    logic             rev_q, cur_bit;

    assign cur_bit = a_q[pos];
    assign partial = b_q << pos;

    // operand copies: written only when a run is accepted
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q   <= '0;
            b_q   <= '0;
            rev_q <= 1'b0;
        end else if (load) begin
            a_q   <= op_a;
            b_q   <= op_b;
            rev_q <= reverse;
        end
    end

    // accumulator: loaded at accept, then only added into or subtracted from
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            acc_q <= '0;
        else if (load)
            acc_q <= acc_in;
        else if (step_en && cur_bit) begin
            if (rev_q)
                acc_q <= acc_q - partial;
            else
                acc_q <= acc_q + partial;
        end
    end

    assign acc_out = acc_q;

    // R9
    zero_bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !cur_bit) |=> $stable(acc_q));

    // R6
    operand_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_en |=> ($stable(a_q) && $stable(b_q) && $stable(rev_q)));

endmodule

// File: rtl/rev_mac.sv
module rev_mac #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             reverse,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic [WIDTH-1:0] acc_in,
    output logic [WIDTH-1:0] acc_out,
    output logic             busy,
    output logic             done
);

    localparam int POS_W = $clog2(WIDTH);

    logic             load, step_en;
    logic [POS_W-1:0] pos;

    rev_mac_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .load    (load),
        .step_en (step_en),
        .pos     (pos),
        .busy    (busy),
        .done    (done)
    );

    rev_mac_datapath #(.WIDTH(WIDTH)) u_dp (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .step_en (step_en),
        .pos     (pos),
        .reverse (reverse),
        .op_a    (op_a),
        .op_b    (op_b),
        .acc_in  (acc_in),
        .acc_out (acc_out)
    );

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(acc_out));

    // R6
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && start) |=> busy);

    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && acc_out == $past(acc_in)));

endmodule

// File: tb/rev_mac_bench.sv
module rev_mac_bench;

    localparam int W = 4;
    localparam int CLK_PERIOD = 10;
    localparam int MOD = 1 << W;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         reverse = 1'b0;
    logic [W-1:0] op_a = '0, op_b = '0, acc_in = '0;
    logic [W-1:0] acc_out;
    logic         busy, done;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rev_mac #(.WIDTH(W)) u_rev_mac (
        .clk(clk), .rst_n(rst_n), .start(start), .reverse(reverse),
        .op_a(op_a), .op_b(op_b), .acc_in(acc_in),
        .acc_out(acc_out), .busy(busy), .done(done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one run; returns the final accumulator and whether the timing matched
    task automatic run_op(input int a, input int b, input int acc, input bit dir,
                          input bit disturb, output int res, output bit timing_ok,
                          output int loaded);
        timing_ok = 1'b1;
        @(negedge clk);
        op_a = W'(a); op_b = W'(b); acc_in = W'(acc); reverse = dir; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        loaded = int'(acc_out);
        if (!busy || done) timing_ok = 1'b0;
        for (int n = 2; n <= W + 2; n++) begin
            if (disturb && n == 3) begin
                start = 1'b1; op_a = ~W'(a); op_b = W'(b + 1); acc_in = W'(acc + 5);
                reverse = ~dir;
            end
            @(posedge clk);
            @(negedge clk);
            if (disturb && n == 3) start = 1'b0;
            if (done !== (n == W + 1)) timing_ok = 1'b0;
            if (busy !== (n <= W + 1)) timing_ok = 1'b0;
            if (n == W + 1) res = int'(acc_out);
        end
    endtask

    initial begin
        int res, back, ld, exp;
        bit tok;
        bit all_fwd, all_rev, all_rt, all_tim, all_load;
        repeat (2) @(negedge clk);
        // R1: reset state
        check(busy == 1'b0, "R1 busy", busy, 0);
        check(done == 1'b0, "R1 done", done, 0);
        check(acc_out == '0, "R1 acc_out", acc_out, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: idle hold under changing acc_in
        acc_in = 4'd9;
        repeat (3) @(negedge clk);
        check(acc_out == '0, "R8 idle hold", acc_out, 0);

        all_fwd = 1; all_rev = 1; all_rt = 1; all_tim = 1; all_load = 1;
        for (int a = 0; a < MOD; a++) begin
            for (int b = 0; b < MOD; b++) begin
                int acc0;
                acc0 = (a * 3 + b * 5 + 7) % MOD;
                run_op(a, b, acc0, 1'b0, 1'b0, res, tok, ld);
                if (ld != acc0) begin all_load = 0;
                    check(0, "R2 load", ld, acc0); end
                if (!tok) begin all_tim = 0; check(0, "R5 timing fwd", a, b); end
                exp = (acc0 + a * b) % MOD;
                if (res != exp) begin all_fwd = 0; check(0, "R3 forward", res, exp); end
                run_op(a, b, res, 1'b1, 1'b0, back, tok, ld);
                if (!tok) begin all_tim = 0; check(0, "R5 timing rev", a, b); end
                exp = ((res - a * b) % MOD + MOD) % MOD;
                if (back != exp) begin all_rev = 0; check(0, "R4 reverse", back, exp); end
                if (back != acc0) begin all_rt = 0; check(0, "R7 round trip", back, acc0); end
            end
        end
        check(all_load, "R2 load sweep", all_load, 1);
        check(all_fwd, "R3 forward sweep", all_fwd, 1);
        check(all_rev, "R4 reverse sweep", all_rev, 1);
        check(all_rt, "R7 round trip sweep", all_rt, 1);
        check(all_tim, "R5 timing sweep", all_tim, 1);

        // R9: multiplier zero leaves the accumulator untouched
        run_op(0, 15, 11, 1'b0, 1'b0, res, tok, ld);
        check(res == 11, "R9 zero multiplier", res, 11);
        // wrap: 15*15 + 15 mod 16 = 240 mod 16 = 0
        run_op(15, 15, 15, 1'b0, 1'b0, res, tok, ld);
        check(res == 0, "R3 wrap", res, 0);
        // R4 wrap: 0 - 15*15 mod 16 = 15
        run_op(15, 15, 0, 1'b1, 1'b0, res, tok, ld);
        check(res == 15, "R4 wrap", res, 15);

        // R6: start and input changes while busy are ignored
        run_op(6, 7, 2, 1'b0, 1'b1, res, tok, ld);
        check(res == (2 + 42) % MOD, "R6 disturbed result", res, (2 + 42) % MOD);
        check(tok, "R6 disturbed timing", tok, 1);

        // R8: after completion, the result holds while acc_in moves
        @(negedge clk);
        acc_in = 4'd1;
        repeat (4) @(negedge clk);
        check(acc_out == W'((2 + 42) % MOD), "R8 hold after done", acc_out, (2 + 42) % MOD);
        check(busy == 1'b0 && done == 1'b0, "R5 idle after done", {busy, done}, 0);

        finished = 1'b1;
    end

    initial begin
        fork
            wait (finished);
            begin
                repeat (100000) @(posedge clk);
                check(0, "watchdog", 0, 1);
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule